// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

The block is a general-purpose up counter, 16 bits wide by default, with one comparator. A 4-bit source select picks what advances the counter. It can be one of eight taps of a free-running system-clock divider. It can be the rising edges of a secondary clock input or of an external clock pin. The last choice is none at all, which stops the counter. Three modes share the one counter:

- **Interval mode** restarts the count on every compare match and toggles the timer output.
- **Capture mode** copies the running count into the reference register on a chosen edge of a capture input.
- **PWM mode** drives the output high from count zero until the compare value. The compare value is double-buffered so that it changes only at counter wrap.

Software reaches the block through a byte-wide register port with a 3-bit address. Each write takes effect in the cycle after the write edge, and reads are combinational. The counter width and the reference width are both set by `CNT_W`. Each of them is read or written as a high byte (bits `CNT_W-1` down to 8, zero-extended) and a low byte. Two sticky flags record overflow and match. Each flag is gated by its own enable onto a level interrupt request.

The control path is a three-state machine:

- **ST_HALT**: the stop select is active.
- **ST_RUN**: the counter is counting.
- **ST_ZERO**: a clear request waits for the next count enable.

Its transitions are:

- **HALT_TO_RUN**: a counting source is selected.
- **RUN_TO_HALT**: the stop select is written.
- **ANY_TO_ZERO**: a control write with the clear bit set.
- **ZERO_DONE**: a count enable arrives, the counter is zeroed, and the machine goes to RUN, or to HALT if the stop select is active.

Counting happens in both HALT and RUN on any enable that arrives.

Top module: `tmr16_multi`

## Requirements
- R1: After reset:
  - control (address 0) reads 0x0F;
  - the flag/enable register (address 1) reads 0;
  - the reference buffer is all ones (address 2 reads the high bits, address 3 reads 0xFF);
  - the count (address 4 high, address 5 low) is 0;
  - tmr_out, irq_ovf and irq_match are low.
- R2: Control bits [3:0] choose the count enable:
  - codes 0..7 give one enable every 2048, 512, 128, 32, 16, 8, 4, 2 system clocks, taken from a divider that starts at zero after reset;
  - code 8 gives one enable per rising edge of sec_clk;
  - code 9 gives one enable per rising edge of ext_clk;
  - both sec_clk and ext_clk pass through two synchroniser flops before their edge is detected;
  - codes 10..15 stop the count, which then holds its value.
- R3: Control bits [5:4] select the mode (0 interval, 1 capture, 2 PWM; 3 behaves as interval). In interval mode, an enable that finds the count equal to the compare value zeroes the count, toggles tmr_out and sets the match flag. Any other enable adds one to the count.
- R4: An enable that finds the count at all ones, and that does not zero it through an interval match, wraps the count to 0 and sets the overflow flag.
- R5: Address 1 holds the overflow flag in bit 0, the match flag in bit 1, the overflow enable in bit 2 and the match enable in bit 3. irq_ovf equals overflow flag AND overflow enable. irq_match equals match flag AND match enable.
- R6: Writing address 1 loads both enables from bits [3:2] and clears each flag whose bit in [1:0] is 1. A flag event in the same cycle wins over the clear.
- R7: In PWM mode:
  - tmr_out is high while count < compare value;
  - the compare value reloads from the reference buffer only on the enable that wraps the count;
  - an enable that finds the count equal to the compare value sets the match flag.
- R8: In capture mode, control bit 6 selects the capture edge of cap_in: 0 for rising, 1 for falling. The edge is detected after two synchroniser flops. On it, the current count is copied into the reference buffer and the match flag is set. The counter keeps running, and tmr_out stays low.
- R9: Writing control with bit 7 set makes the next count enable load 0 into the count, with no match or overflow. Bit 7 always reads back 0.
- R10: Writes to address 2 set the reference high bits and writes to address 3 set the low byte. Outside PWM mode, the compare value follows the buffer one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| sec_clk | input | 1 | Secondary clock, counted on rising edges (code 8) |
| ext_clk | input | 1 | External clock pin, counted on rising edges (code 9) |
| cap_in | input | 1 | Capture trigger input |
| tmr_out | output | 1 | Interval toggle or PWM waveform |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_match | output | 1 | Match / capture interrupt request |

## Verification
The assertions assume a few things about the inputs:

- bus_we is a single-cycle strobe on a valid address;
- sec_clk, ext_clk and cap_in stay at each level for at least two system clocks, so the two-flop synchronisers see every transition;
- reset is applied before the first edge.

The stimulus drives every input at the falling clock edge and holds each level of the asynchronous inputs for three or more cycles. A narrower counter width is used so that wrap and PWM periods fit the run.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    // Mode codes held in control bits [5:4]
    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_CAPTURE  = 2'd1,
        MODE_PWM      = 2'd2,
        MODE_ALT      = 2'd3
    } tmr_mode_e;

    // Control path of the counter
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_ZERO = 2'd2
    } tmr_state_e;

    localparam int PRE_W     = 11;
    localparam int NUM_TAPS  = 8;
    localparam logic [3:0] SEL_SEC  = 4'd8;
    localparam logic [3:0] SEL_EXT  = 4'd9;
    localparam logic [3:0] SEL_STOP = 4'd10;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_IRQ    = 3'd1;
    localparam logic [2:0] ADDR_REF_HI = 3'd2;
    localparam logic [2:0] ADDR_REF_LO = 3'd3;
    localparam logic [2:0] ADDR_CNT_HI = 3'd4;
    localparam logic [2:0] ADDR_CNT_LO = 3'd5;

    // Number of low divider bits that must be all ones for tap i
    // (tap 0 = /2048 ... tap 7 = /2)
    function automatic int tap_bits(input int i);
        if (i < 3) return 11 - 2 * i;
        return 8 - i;
    endfunction

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic want_fall,
    output logic evt
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    always_comb begin
        if (want_fall) evt = !s2_q && s3_q;
        else           evt = s2_q && !s3_q;
    end
endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
    import tmr16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel,
    input  logic       sec_clk,
    input  logic       ext_clk,
    output logic       tick
);
    logic [PRE_W-1:0]    presc_q;
    logic [NUM_TAPS-1:0] tap;
    logic                sec_evt;
    logic                ext_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int LB = tap_bits(g);
        assign tap[g] = &presc_q[LB-1:0];
    end

    tmr16_sync sec_sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (sec_clk),
        .want_fall (1'b0),
        .evt       (sec_evt)
    );

    tmr16_sync ext_sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (ext_clk),
        .want_fall (1'b0),
        .evt       (ext_evt)
    );

    always_comb begin
        if (sel < 4'd8)          tick = tap[sel[2:0]];
        else if (sel == SEL_SEC) tick = sec_evt;
        else if (sel == SEL_EXT) tick = ext_evt;
        else                     tick = 1'b0;
    end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             stop_sel,
    input  tmr_mode_e        mode,
    input  logic             clear_req,
    input  logic             cap_evt,
    input  logic             ref_wr_hi,
    input  logic             ref_wr_lo,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] buf_q,
    output logic             tmr_out,
    output logic             ovf_evt,
    output logic             match_evt
);
    localparam int HI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d, cmp_d, buf_d;
    logic             tog_q, tog_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (!stop_sel) state_d = ST_RUN;       // HALT_TO_RUN
            ST_RUN:  if (stop_sel)  state_d = ST_HALT;      // RUN_TO_HALT
            ST_ZERO: if (tick) state_d = stop_sel ? ST_HALT : ST_RUN; // ZERO_DONE
            default: state_d = ST_HALT;
        endcase
        if (clear_req) state_d = ST_ZERO;                   // ANY_TO_ZERO
    end

    // Datapath outputs per state
    always_comb begin
        cnt_d     = cnt_q;
        tog_d     = tog_q;
        ovf_evt   = 1'b0;
        match_evt = 1'b0;
        cmp_d     = (mode == MODE_PWM) ? cmp_q : buf_q;
        unique case (state_q)
            ST_ZERO: begin
                if (tick) cnt_d = '0;
            end
            ST_HALT, ST_RUN: begin
                if (tick) begin
                    unique case (mode)
                        MODE_PWM: begin
                            cnt_d = cnt_q + 1'b1;
                            if (cnt_q == CNT_MAX) begin
                                ovf_evt = 1'b1;
                                cmp_d   = buf_q;
                            end
                            if (cnt_q == cmp_q) match_evt = 1'b1;
                        end
                        MODE_CAPTURE: begin
                            cnt_d = cnt_q + 1'b1;
                            if (cnt_q == CNT_MAX) ovf_evt = 1'b1;
                        end
                        MODE_INTERVAL, MODE_ALT: begin
                            if (cnt_q == cmp_q) begin
                                cnt_d     = '0;
                                tog_d     = !tog_q;
                                match_evt = 1'b1;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                                if (cnt_q == CNT_MAX) ovf_evt = 1'b1;
                            end
                        end
                        default: cnt_d = cnt_q;
                    endcase
                end
            end
            default: cnt_d = cnt_q;
        endcase
        if (cap_evt) match_evt = 1'b1;
    end

    // Reference buffer: capture beats a bus write
    always_comb begin
        buf_d = buf_q;
        if (cap_evt) begin
            buf_d = cnt_q;
        end else begin
            if (ref_wr_hi) buf_d[CNT_W-1:8] = wdata[HI_W-1:0];
            if (ref_wr_lo) buf_d[7:0]       = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '1;
            buf_q <= '1;
            tog_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            cmp_q <= cmp_d;
            buf_q <= buf_d;
            tog_q <= tog_d;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_PWM:     tmr_out = (cnt_q < cmp_q);
            MODE_CAPTURE: tmr_out = 1'b0;
            default:      tmr_out = tog_q;
        endcase
    end
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    output logic [7:0] bus_rdata,
    input  logic       sec_clk,
    input  logic       ext_clk,
    input  logic       cap_in,
    output logic       tmr_out,
    output logic       irq_ovf,
    output logic       irq_match
);
    logic [3:0]       sel_q;
    tmr_mode_e        mode_q;
    logic             edge_q;
    logic             ovf_flag, mat_flag, ovf_en, mat_en;
    logic             tick, cap_raw, cap_evt;
    logic             ovf_evt, match_evt;
    logic [CNT_W-1:0] cnt_q, cmp_q, buf_q;
    logic [15:0]      cnt_ext, buf_ext;
    logic             wr_ctrl, wr_irq, wr_hi, wr_lo;

    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_irq  = bus_we && (bus_addr == ADDR_IRQ);
    assign wr_hi   = bus_we && (bus_addr == ADDR_REF_HI);
    assign wr_lo   = bus_we && (bus_addr == ADDR_REF_LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 4'hF;
            mode_q <= MODE_INTERVAL;
            edge_q <= 1'b0;
        end else if (wr_ctrl) begin
            sel_q  <= bus_wdata[3:0];
            mode_q <= tmr_mode_e'(bus_wdata[5:4]);
            edge_q <= bus_wdata[6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            mat_flag <= 1'b0;
            ovf_en   <= 1'b0;
            mat_en   <= 1'b0;
        end else begin
            ovf_flag <= (ovf_flag && !(wr_irq && bus_wdata[0])) || ovf_evt;
            mat_flag <= (mat_flag && !(wr_irq && bus_wdata[1])) || match_evt;
            if (wr_irq) begin
                ovf_en <= bus_wdata[2];
                mat_en <= bus_wdata[3];
            end
        end
    end

    tmr16_tick tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_q),
        .sec_clk (sec_clk),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    tmr16_sync cap_sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (cap_in),
        .want_fall (edge_q),
        .evt       (cap_raw)
    );

    assign cap_evt = cap_raw && (mode_q == MODE_CAPTURE);

    tmr16_core #(.CNT_W(CNT_W)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .stop_sel  (sel_q >= SEL_STOP),
        .mode      (mode_q),
        .clear_req (wr_ctrl && bus_wdata[7]),
        .cap_evt   (cap_evt),
        .ref_wr_hi (wr_hi),
        .ref_wr_lo (wr_lo),
        .wdata     (bus_wdata),
        .cnt_q     (cnt_q),
        .cmp_q     (cmp_q),
        .buf_q     (buf_q),
        .tmr_out   (tmr_out),
        .ovf_evt   (ovf_evt),
        .match_evt (match_evt)
    );

    assign cnt_ext = 16'(cnt_q);
    assign buf_ext = 16'(buf_q);

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:   bus_rdata = {1'b0, edge_q, mode_q, sel_q};
            ADDR_IRQ:    bus_rdata = {4'b0, mat_en, ovf_en, mat_flag, ovf_flag};
            ADDR_REF_HI: bus_rdata = buf_ext[15:8];
            ADDR_REF_LO: bus_rdata = buf_ext[7:0];
            ADDR_CNT_HI: bus_rdata = cnt_ext[15:8];
            ADDR_CNT_LO: bus_rdata = cnt_ext[7:0];
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq_ovf   = ovf_flag && ovf_en;
    assign irq_match = mat_flag && mat_en;
endmodule

// File: rtl/tmr16_multi_chk.sv
module tmr16_multi_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       sel_q,
    input logic [1:0]       mode_q,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] buf_q,
    input logic             ovf_flag,
    input logic             mat_flag,
    input logic             ovf_en,
    input logic             mat_en,
    input logic             irq_ovf,
    input logic             irq_match
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q >= 4'd10) |=> $stable(cnt_q));

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

    p_ovf_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt_q) == ALL1 && cnt_q == '0));

    p_irq_ovf_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> (ovf_en && ovf_flag));

    p_irq_match_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |-> (mat_en && mat_flag));

    p_pwm_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == 2'd2 && cmp_q != $past(cmp_q)) |->
            ($past(cnt_q) == ALL1 && $past(tick)));

    p_capture_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mat_flag) && $past(mode_q) == 2'd1) |-> (buf_q == $past(cnt_q)));
endmodule

bind tmr16_multi tmr16_multi_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_q     (sel_q),
    .mode_q    (mode_q),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .buf_q     (buf_q),
    .ovf_flag  (ovf_flag),
    .mat_flag  (mat_flag),
    .ovf_en    (ovf_en),
    .mat_en    (mat_en),
    .irq_ovf   (irq_ovf),
    .irq_match (irq_match)
);

// File: tb/tmr16_multi_tb_top.sv
`timescale 1ns/1ps
module tmr16_multi_tb_top;
    localparam int CW   = 10;
    localparam int MAXV = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd5;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       sec_clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       cap_in = 1'b0;
    logic       tmr_out, irq_ovf, irq_match;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr16_multi #(.CNT_W(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .sec_clk   (sec_clk),
        .ext_clk   (ext_clk),
        .cap_in    (cap_in),
        .tmr_out   (tmr_out),
        .irq_ovf   (irq_ovf),
        .irq_match (irq_match)
    );

    // ---------------- behavioural reference model ----------------
    int m_pre, m_cnt, m_cmp, m_buf, m_sel, m_mode, m_edge;
    int m_tog, m_pend, m_ovf_f, m_mat_f, m_ovf_en, m_mat_en;
    int hist_s[3], hist_e[3], hist_c[3];

    function automatic int divisor(input int s);
        case (s)
            0: return 2048;  1: return 512; 2: return 128; 3: return 32;
            4: return 16;    5: return 8;   6: return 4;   default: return 2;
        endcase
    endfunction

    function automatic int m_read(input int a);
        case (a)
            0: return (m_edge << 6) | (m_mode << 4) | m_sel;
            1: return (m_mat_en << 3) | (m_ovf_en << 2) | (m_mat_f << 1) | m_ovf_f;
            2: return m_buf >> 8;
            3: return m_buf & 255;
            4: return m_cnt >> 8;
            5: return m_cnt & 255;
            default: return 0;
        endcase
    endfunction

    function automatic int m_out();
        if (m_mode == 2) return (m_cnt < m_cmp) ? 1 : 0;
        if (m_mode == 1) return 0;
        return m_tog;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_cmp = MAXV; m_buf = MAXV; m_sel = 15;
            m_mode = 0; m_edge = 0; m_tog = 0; m_pend = 0;
            m_ovf_f = 0; m_mat_f = 0; m_ovf_en = 0; m_mat_en = 0;
            for (int i = 0; i < 3; i++) begin hist_s[i] = 0; hist_e[i] = 0; hist_c[i] = 0; end
        end else begin
            int t, cap, ov, mt, ncnt, ncmp, nbuf;
            t = 0;
            if (m_sel < 8)       t = ((m_pre % divisor(m_sel)) == divisor(m_sel) - 1);
            else if (m_sel == 8) t = (hist_s[1] == 1 && hist_s[2] == 0);
            else if (m_sel == 9) t = (hist_e[1] == 1 && hist_e[2] == 0);
            cap = 0;
            if (m_mode == 1)
                cap = m_edge ? (hist_c[1] == 0 && hist_c[2] == 1) : (hist_c[1] == 1 && hist_c[2] == 0);
            ov = 0; mt = 0; ncnt = m_cnt;
            ncmp = (m_mode == 2) ? m_cmp : m_buf;
            if (t) begin
                if (m_pend) begin
                    ncnt = 0; m_pend = 0;
                end else if (m_mode == 2) begin
                    ncnt = (m_cnt + 1) % (MAXV + 1);
                    if (m_cnt == MAXV) begin ov = 1; ncmp = m_buf; end
                    if (m_cnt == m_cmp) mt = 1;
                end else if (m_mode == 1) begin
                    ncnt = (m_cnt + 1) % (MAXV + 1);
                    if (m_cnt == MAXV) ov = 1;
                end else if (m_cnt == m_cmp) begin
                    ncnt = 0; m_tog = 1 - m_tog; mt = 1;
                end else begin
                    ncnt = (m_cnt + 1) % (MAXV + 1);
                    if (m_cnt == MAXV) ov = 1;
                end
            end
            if (cap) mt = 1;
            nbuf = m_buf;
            if (cap) nbuf = m_cnt;
            else if (bus_we && bus_addr == 2) nbuf = (m_buf & 255) | ((bus_wdata & ((1 << (CW - 8)) - 1)) << 8);
            else if (bus_we && bus_addr == 3) nbuf = (m_buf & ~255) | bus_wdata;
            if (bus_we && bus_addr == 1) begin
                if (bus_wdata[0]) m_ovf_f = 0;
                if (bus_wdata[1]) m_mat_f = 0;
                m_ovf_en = bus_wdata[2];
                m_mat_en = bus_wdata[3];
            end
            if (ov) m_ovf_f = 1;
            if (mt) m_mat_f = 1;
            if (bus_we && bus_addr == 0) begin
                m_sel = bus_wdata[3:0]; m_mode = bus_wdata[5:4]; m_edge = bus_wdata[6];
                if (bus_wdata[7]) m_pend = 1;
            end
            m_cnt = ncnt; m_cmp = ncmp; m_buf = nbuf;
            hist_s[2] = hist_s[1]; hist_s[1] = hist_s[0]; hist_s[0] = sec_clk;
            hist_e[2] = hist_e[1]; hist_e[1] = hist_e[0]; hist_e[0] = ext_clk;
            hist_c[2] = hist_c[1]; hist_c[1] = hist_c[0]; hist_c[0] = cap_in;
            m_pre = (m_pre + 1) % 2048;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            string rt;
            check((m_mode == 2) ? "R7" : "R3", "tmr_out", int'(tmr_out), m_out());
            check("R5", "irq_ovf", int'(irq_ovf), m_ovf_f & m_ovf_en);
            check("R5", "irq_match", int'(irq_match), m_mat_f & m_mat_en);
            case (bus_addr)
                3'd0: rt = "R9";
                3'd1: rt = "R6";
                3'd2, 3'd3: rt = "R10";
                default: rt = "R3";
            endcase
            check(rt, "bus_rdata", int'(bus_rdata), m_read(int'(bus_addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 8'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd5;
    endtask

    task automatic rd_lit(input int a, input int exp, input string req);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        check(req, "read", int'(bus_rdata), exp);
    endtask

    task automatic rd_mod(input int a, input string req);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        check(req, "read vs model", int'(bus_rdata), m_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_lit(0, 8'h0F, "R1");
        rd_lit(1, 8'h00, "R1");
        rd_lit(2, 8'h03, "R1");
        rd_lit(3, 8'hFF, "R1");
        rd_lit(5, 8'h00, "R1");
        check("R1", "tmr_out", int'(tmr_out), 0);
        check("R1", "irq_ovf", int'(irq_ovf), 0);

        // R3/R10: interval mode, /2, compare 5
        wr(1, 8'h0C);
        wr(2, 8'h00);
        wr(3, 8'h05);
        wr(0, 8'h07);
        idle(60);
        rd_mod(5, "R3");
        rd_mod(1, "R5");
        // R6: W1C on the match flag
        wr(1, 8'h0E);
        rd_mod(1, "R6");

        // R9: clear request, bit 7 reads back 0
        wr(0, 8'h87);
        rd_lit(0, 8'h07, "R9");
        rd_mod(5, "R9");

        // R2: slowest tap, /2048
        wr(3, 8'h02);
        wr(0, 8'h00);
        idle(2048 * 4);
        rd_mod(5, "R2");
        // R2: /16 tap
        wr(0, 8'h04);
        idle(200);
        rd_mod(5, "R2");

        // R2: stop select holds the count
        wr(0, 8'h0A);
        rd_mod(5, "R2");
        snap = int'(bus_rdata);
        idle(50);
        rd_lit(5, snap, "R2");

        // R4/R5: overflow in capture mode with enables off, then on
        wr(1, 8'h03);
        wr(0, 8'h17);
        idle(2 * (MAXV + 1) + 20);
        rd_mod(1, "R4");
        check("R5", "irq_ovf gated", int'(irq_ovf), 0);
        wr(1, 8'h04);
        check("R5", "irq_ovf enabled", int'(irq_ovf), 1);
        rd_mod(4, "R4");

        // R8: capture on rising then falling edge
        wr(1, 8'h0F);
        cap_in = 1'b1;
        idle(8);
        rd_mod(3, "R8");
        rd_mod(2, "R8");
        rd_mod(1, "R8");
        check("R8", "tmr_out in capture", int'(tmr_out), 0);
        wr(0, 8'h57);
        idle(5);
        cap_in = 1'b0;
        idle(8);
        rd_mod(3, "R8");
        rd_mod(1, "R8");

        // R7: PWM with a buffered compare change mid period
        wr(1, 8'h0F);
        wr(2, 8'h00);
        wr(3, 8'd100);
        wr(0, 8'h27);
        idle(2 * (MAXV + 1) + 50);
        check("R7", "pwm output vs model", int'(tmr_out), m_out());
        wr(2, 8'h01);
        wr(3, 8'h20);
        idle(300);
        check("R7", "pwm output before reload", int'(tmr_out), m_out());
        idle(2 * (MAXV + 1) * 2);
        rd_mod(1, "R7");

        // R2: external pin source, interval, compare 7
        wr(2, 8'h00);
        wr(3, 8'h07);
        wr(0, 8'h89);
        for (int i = 0; i < 40; i++) begin
            ext_clk = ~ext_clk;
            idle(3);
        end
        rd_mod(5, "R2");
        // R2: secondary clock source
        wr(0, 8'h08);
        for (int i = 0; i < 40; i++) begin
            sec_clk = ~sec_clk;
            idle(4);
        end
        rd_mod(5, "R2");
        check("R3", "toggle output", int'(tmr_out), m_out());

        // R10: compare follows buffer outside PWM
        wr(3, 8'h03);
        wr(0, 8'h07);
        idle(30);
        rd_mod(3, "R10");
        rd_mod(5, "R10");

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule